// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an 8-bit SPI master. Each transfer drives one byte out on `mosi` and takes one byte in from `miso` at the same time. Three byte-wide stores sit between the host and the serial line: a transmit holding buffer, a shift engine and a receive buffer. Because of the holding buffer, the host can queue the next byte while the current byte is still shifting. A byte queued early enough follows the current one with no break in `sclk`.

The serial bit clock is the system clock divided by two. A one-bit divider starts toggling as soon as the block is enabled and then runs freely. The host uses a small register port with three addresses: data, control and status. Through it the host sets the enable, the clock phase (SPI mode 0 or mode 1) and the bit order. It also polls three flags: holding buffer empty, receive buffer full and byte finished. An overrun flag reports a write to a full holding buffer. Clearing the enable stops the serial line at once and clears every status flag. The byte stores keep their contents.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, `sclk` and `mosi` are 0, the control register reads 0x00, the data address reads 0x00 and the status register reads 0x01.
- R2: The bit clock is the system clock divided by two. Each `sclk` period lasts 2 clock cycles. `sclk` is 0 whenever no byte is being shifted.
- R3: In mode 0 (control bit 1 = 0), `sclk` idles low. `mosi` changes on the falling edge of `sclk` and `miso` is sampled on the rising edge.
- R4: In mode 1 (control bit 1 = 1), `sclk` also idles low. `mosi` changes on the rising edge of `sclk` and `miso` is sampled on the falling edge.
- R5: Control bit 2 sets the bit order. When it is 1, bit 0 goes first. When it is 0, bit 7 goes first. The same order applies to transmit and receive. While no byte is shifting, `mosi` shows the shift-register bit that would go first.
- R6: A write to address 0 while the holding buffer is empty queues the byte. If the engine is idle, it loads the byte at the next bit-clock boundary, and holding-buffer-empty (status bit 0) reads 1 again within 3 cycles of the write.
- R7: A byte queued at least one system cycle (half a bit period) before the last bit of the current byte ends is shifted with no gap: consecutive `sclk` rising edges stay 2 cycles apart. If no byte is queued, `sclk` stays low once the last bit ends.
- R8: After the eighth sample, the received byte is stored in the receive buffer and receive-full (status bit 1) is set. A read of address 0 returns that byte and clears receive-full.
- R9: Byte-finished (status bit 2) is set at the end of each byte. A read of the status register (address 2) returns the flags as they stood before the read, then clears byte-finished and overrun.
- R10: A write to address 0 while holding-buffer-empty is 0 is ignored: the queued byte is not replaced. Overrun (status bit 3) is set.
- R11: Clearing the enable (control bit 0) forces `sclk` low on the next cycle, clears all status flags and drops any queued byte. The receive buffer keeps its contents. Setting the enable again does not resume the interrupted byte.
- R12: Register map: address 0 writes the holding buffer and reads the receive buffer; address 1 is control {bit 2 order, bit 1 mode, bit 0 enable}; address 2 is read-only status. Read data appears on `bus_rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check, on every cycle, these rules:
- the divider toggles while the block is enabled;
- `sclk` falls on the cycle after a disable;
- `sclk` changes level at every sampling point of a byte;
- status flags are set when a byte ends and cleared while the block is disabled;
- a write to a full holding buffer leaves that buffer unchanged.

Only the bench's scenarios can show the rest:
- the serial bit values and their order;
- the rising-edge spacing across queued bytes;
- the clear-on-read behaviour seen from the host;
- the fact that a disabled transfer does not resume.

The bench gets these by acting as an SPI slave on the pins and comparing with expected values that it computes itself.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  // control bit positions
  localparam int C_EN   = 0;
  localparam int C_MODE = 1;
  localparam int C_LSBF = 2;

  // status bit positions
  localparam int S_TXE  = 0;
  localparam int S_RXF  = 1;
  localparam int S_DONE = 2;
  localparam int S_OVR  = 3;
  localparam int S_W    = 4;
endpackage

// File: rtl/sdm_bitdiv.sv
module sdm_bitdiv (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic div_q,
  output logic div_n
);
  // held at 0 while disabled, goes to 1 on the first edge after enable
  assign div_n = en ? ~div_q : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) div_q <= 1'b0;
    else     div_q <= div_n;
  end

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    en |=> (div_q != $past(div_q)));  // R2
endmodule

// File: rtl/sdm_engine.sv
module sdm_engine #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          div_q,
  input  logic          div_n,
  input  logic          cpha,
  input  logic          lsbf,
  input  logic          tx_pend,
  input  logic [DW-1:0] tx_data,
  input  logic          miso,
  output logic          take,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          sclk,
  output logic          mosi
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] tsh_q, tsh_n, rsh_q;
  logic          sample, last;

  // leading half of a bit: div_q == 0; trailing half: div_q == 1
  assign sample    = en && busy_q && !div_q;
  assign last      = (cnt_q == LAST);
  assign rx_byte   = lsbf ? {miso, rsh_q[DW-1:1]} : {rsh_q[DW-2:0], miso};
  assign byte_done = sample && last;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    tsh_n  = tsh_q;
    take   = 1'b0;
    if (!en) begin
      busy_n = 1'b0;
      cnt_n  = '0;
    end else if (div_q) begin
      if (!busy_q || last) begin
        cnt_n = '0;
        if (tx_pend) begin
          tsh_n  = tx_data;
          busy_n = 1'b1;
          take   = 1'b1;
        end else begin
          busy_n = 1'b0;
        end
      end else begin
        tsh_n = lsbf ? (tsh_q >> 1) : (tsh_q << 1);
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tsh_q  <= '0;
      rsh_q  <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      tsh_q  <= tsh_n;
      if (sample) rsh_q <= rx_byte;
      sclk   <= busy_n && (cpha ? !div_n : div_n);
      mosi   <= lsbf ? tsh_n[0] : tsh_n[DW-1];
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sclk);  // R11

  AST_SAMPLE_EDGE: assert property (@(posedge clk) disable iff (rst)
    (sample && cpha == $past(cpha)) |=> (sclk != $past(sclk)));  // R3
endmodule

// File: rtl/sdm_regs.sv
module sdm_regs
  import sdm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              take,
  input  logic              byte_done,
  input  logic [DW-1:0]     rx_byte,
  output logic [DW-1:0]     rdata,
  output logic              en,
  output logic              cpha,
  output logic              lsbf,
  output logic              tx_pend,
  output logic [DW-1:0]     tx_buf
);
  logic [DW-1:0] rx_buf;
  logic          rx_full, done_q, ovr_q;
  logic          wr_data, wr_ctrl, rd_data, rd_stat;
  logic [S_W-1:0] stat;

  assign wr_data = wr_en && (addr == A_DATA);
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign rd_data = rd_en && (addr == A_DATA);
  assign rd_stat = rd_en && (addr == A_STAT);

  always_comb begin
    stat         = '0;
    stat[S_TXE]  = ~tx_pend;
    stat[S_RXF]  = rx_full;
    stat[S_DONE] = done_q;
    stat[S_OVR]  = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      cpha    <= 1'b0;
      lsbf    <= 1'b0;
      tx_pend <= 1'b0;
      tx_buf  <= '0;
      rx_buf  <= '0;
      rx_full <= 1'b0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr_ctrl) begin
        en   <= wdata[C_EN];
        cpha <= wdata[C_MODE];
        lsbf <= wdata[C_LSBF];
      end
      if (byte_done) rx_buf <= rx_byte;
      if (!en) begin
        tx_pend <= 1'b0;
        rx_full <= 1'b0;
        done_q  <= 1'b0;
        ovr_q   <= 1'b0;
      end else begin
        if (take) tx_pend <= 1'b0;
        if (rd_stat) begin
          done_q <= 1'b0;
          ovr_q  <= 1'b0;
        end
        if (rd_data) rx_full <= 1'b0;
        if (wr_data) begin
          if (tx_pend) ovr_q <= 1'b1;
          else begin
            tx_buf  <= wdata;
            tx_pend <= 1'b1;
          end
        end
        if (byte_done) begin
          rx_full <= 1'b1;
          done_q  <= 1'b1;
        end
      end
      if (rd_en) begin
        case (addr)
          A_DATA:  rdata <= rx_buf;
          A_CTRL:  rdata <= {{(DW-3){1'b0}}, lsbf, cpha, en};
          A_STAT:  rdata <= {{(DW-S_W){1'b0}}, stat};
          default: rdata <= '0;
        endcase
      end
    end
  end

  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_data && en && tx_pend) |=> (ovr_q && $stable(tx_buf)));  // R10

  AST_RX_SET: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> (rx_full && done_q));  // R8

  AST_DIS_CLR: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tx_pend && !rx_full && !done_q && !ovr_q));  // R11
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import sdm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic          en, cpha, lsbf, tx_pend, take, byte_done;
  logic          div_q, div_n;
  logic [DW-1:0] tx_buf, rx_byte;

  sdm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .take(take), .byte_done(byte_done), .rx_byte(rx_byte),
    .rdata(bus_rdata), .en(en), .cpha(cpha), .lsbf(lsbf), .tx_pend(tx_pend),
    .tx_buf(tx_buf)
  );

  sdm_bitdiv u_div (
    .clk(clk), .rst(rst), .en(en), .div_q(div_q), .div_n(div_n)
  );

  sdm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .en(en), .div_q(div_q), .div_n(div_n), .cpha(cpha),
    .lsbf(lsbf), .tx_pend(tx_pend), .tx_data(tx_buf), .miso(miso),
    .take(take), .byte_done(byte_done), .rx_byte(rx_byte), .sclk(sclk),
    .mosi(mosi)
  );
endmodule

// File: tb/test_spi_dbuf_master.sv
module test_spi_dbuf_master;
  logic       clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, miso = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk, mosi;

  spi_dbuf_master i_spi_dbuf_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model state
  logic [7:0] txb [0:3];
  logic [7:0] sb  [0:3];
  logic       cap [0:63];
  bit   mode_b = 0, lsbf_b = 0, sclk_prev = 0;
  int   nb = 1, nsamp = 0, nrise = 0, nmiso = 0, last_rise = 0, max_gap = 0;

  function automatic logic sbit(int n);
    if (n >= 8 * nb) return 1'b0;
    return lsbf_b ? sb[n/8][n%8] : sb[n/8][7 - n%8];
  endfunction

  always @(negedge clk) begin
    bit rise, fall;
    rise = sclk && !sclk_prev;
    fall = !sclk && sclk_prev;
    if (rise) begin
      if (nrise > 0 && cyc - last_rise > max_gap) max_gap = cyc - last_rise;
      last_rise = cyc;
      nrise++;
    end
    if (mode_b ? fall : rise) begin
      if (nsamp < 64) cap[nsamp] = mosi;
      nsamp++;
    end
    if (mode_b ? rise : fall) begin
      miso = sbit(nmiso);
      nmiso++;
    end
    sclk_prev = sclk;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic arm(input bit md, input bit lf, input int n);
    mode_b = md; lsbf_b = lf; nb = n;
    nsamp = 0; nrise = 0; max_gap = 0;
    nmiso = md ? 0 : 1;
    miso  = md ? 1'b0 : sbit(0);
    bus_write(2'd1, {5'b0, lf, md, 1'b1});
  endtask

  // ovr: write a second byte on the very next cycle; keep: skip the final reads
  task automatic run(input bit md, input bit lf, input int n, input bit ovr, input bit keep);
    logic [7:0] v;
    int mism;
    arm(md, lf, n);
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin
        v = '0;
        while (!v[0]) bus_read(2'd2, v);
      end
      if (k == 0 && ovr) begin
        @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = txb[0];
        @(negedge clk); bus_wdata = ~txb[0];
        @(negedge clk); bus_wr = 1'b0;
      end else begin
        bus_write(2'd0, txb[k]);
        if (k == 0) begin
          repeat (2) @(negedge clk);
          bus_read(2'd2, v);
          check("R6 buffer empty again", int'(v[0]), 1);
        end
      end
    end
    while (nsamp < 8 * n) @(negedge clk);
    repeat (24) @(negedge clk);
    mism = 0;
    for (int i = 0; i < 8 * n; i++)
      if (cap[i] !== (lf ? txb[i/8][i%8] : txb[i/8][7 - i%8])) mism++;
    check(md ? "R4 mosi bits" : "R3 mosi bits", mism, 0);
    check("R5 order, R10 single byte sent", nsamp, 8 * n);
    check("R2 sclk periods", nrise, 8 * n);
    check("R7 rise spacing", max_gap, 2);
    check("R2 sclk idle low", int'(sclk), 0);
    if (!keep) begin
      bus_read(2'd2, v);
      check(ovr ? "R10 overrun status" : "R9 status after byte", v, ovr ? 8'h0F : 8'h07);
      bus_read(2'd0, v);
      check(lf ? "R8 rx byte R5" : "R8 rx byte", v, sb[n-1]);
      bus_read(2'd2, v);
      check("R9 flags cleared by reads", v, 8'h01);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int saved;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sclk reset", int'(sclk), 0);
    check("R1 mosi reset", int'(mosi), 0);
    bus_read(2'd2, v); check("R1 status reset", v, 8'h01);
    bus_read(2'd1, v); check("R1 control reset", v, 8'h00);
    bus_read(2'd0, v); check("R1 data reset", v, 8'h00);

    // directed: mode 0, msb first, two bytes back to back
    txb[0] = 8'hA5; txb[1] = 8'h3C; sb[0] = 8'h96; sb[1] = 8'hC3;
    run(1'b0, 1'b0, 2, 1'b0, 1'b0);
    bus_read(2'd1, v); check("R12 control readback", v, 8'h01);
    // directed: mode 1, lsb first, three bytes
    txb[0] = 8'h01; txb[1] = 8'h80; txb[2] = 8'h5A; sb[0] = 8'h0F; sb[1] = 8'hF0; sb[2] = 8'hB2;
    run(1'b1, 1'b1, 3, 1'b0, 1'b0);
    // directed: overrun write
    txb[0] = 8'h6E; sb[0] = 8'h29;
    run(1'b0, 1'b1, 1, 1'b1, 1'b0);

    // directed: disable after a complete byte keeps rx data
    txb[0] = 8'hD4; sb[0] = 8'h71;
    run(1'b1, 1'b0, 1, 1'b0, 1'b1);
    bus_write(2'd1, 8'h00);
    bus_read(2'd2, v); check("R11 status cleared", v, 8'h01);
    bus_read(2'd0, v); check("R11 rx kept", v, 8'h71);
    bus_read(2'd1, v); check("R12 control off", v, 8'h00);

    // directed: disable in the middle of a byte
    txb[0] = 8'hE7; sb[0] = 8'h18;
    arm(1'b0, 1'b0, 1);
    bus_write(2'd0, txb[0]);
    while (nrise < 3) @(negedge clk);
    bus_write(2'd1, 8'h00);
    @(negedge clk);
    check("R11 sclk low on disable", int'(sclk), 0);
    bus_read(2'd2, v); check("R11 status after abort", v, 8'h01);
    saved = nrise;
    bus_write(2'd1, 8'h01);
    repeat (40) @(negedge clk);
    check("R11 no resume", nrise, saved);

    // constrained random transfers
    for (int it = 0; it < 10; it++) begin
      int n;
      bit md, lf;
      md = 1'($urandom % 2);
      lf = 1'($urandom % 2);
      n  = 1 + int'($urandom % 4);
      for (int k = 0; k < 4; k++) begin
        txb[k] = 8'($urandom);
        sb[k]  = 8'($urandom);
      end
      run(md, lf, n, 1'b0, 1'b0);
    end
    finish_up();
  end
endmodule